// File: doc/BRIEF.md
# Add-Compare-Select Element

This block computes one trellis state update in a Viterbi decoder. It takes two predecessor path metrics, named upper and lower, and the branch metric that belongs to each transition. It adds each pair with an unsigned adder that clamps at full scale rather than wrapping. It keeps the smaller of the two candidates as the new state metric and reports which predecessor supplied it as a one-bit decision.

The decision comes from the carry-out of a carry-only chain fed with the upper candidate and the inverted lower candidate. No difference word is ever formed. When the two candidates are equal, the upper one is kept.

A parameter places a register on the metric and decision outputs. The output register is present by default. Without it, the block is fully combinational.

Top module: `acs_unit`

## Requirements
- R1: The upper candidate equals `sm_up + bm_up` when that sum fits in 8 bits. Otherwise it is 255 (all ones). It never wraps.
- R2: The lower candidate equals `sm_lo + bm_lo` when that sum fits in 8 bits. Otherwise it is 255. It never wraps.
- R3: `path_sel` is 1 exactly when the upper candidate is strictly greater than the lower candidate.
- R4: When the two candidates are equal, including the case where both are clamped at 255, `path_sel` is 0.
- R5: `nsm` carries the upper candidate when `path_sel` is 0 and the lower candidate when `path_sel` is 1. In both cases `nsm` is the minimum of the two candidates.
- R6: With the output register enabled (`REG_OUT=1`, the default), `nsm` and `path_sel` reflect the inputs present at the previous rising clock edge.
- R7: While `rst_n` is low, `nsm` and `path_sel` are 0, whatever the data inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| sm_up | input | 8 | Upper predecessor state metric, unsigned |
| sm_lo | input | 8 | Lower predecessor state metric, unsigned |
| bm_up | input | 5 | Branch metric on the upper transition, unsigned |
| bm_lo | input | 5 | Branch metric on the lower transition, unsigned |
| nsm | output | 8 | New state metric, the smaller candidate |
| path_sel | output | 1 | Decision: 0 means the upper candidate survived, 1 means the lower one did |

## Verification
The assertions assume that all four data inputs carry known 0/1 values on every rising edge while reset is released. They also assume the inputs change only away from that edge.

The bench meets both assumptions. It drives every input from the start of reset and changes the inputs only on falling edges. It covers directed corners: zero, both sides clamped, one side clamped, exact ties, and candidates one apart. It then runs a long run of uniformly random vectors, where each input spans its full range.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int unsigned SM_W_DEF = 8;
  localparam int unsigned BM_W_DEF = 5;

  // Decision encoding carried on path_sel
  typedef enum logic {
    PICK_UPPER = 1'b0,
    PICK_LOWER = 1'b1
  } pick_e;
endpackage

// File: rtl/acs_sat_add.sv
module acs_sat_add #(
  parameter int unsigned SM_W = acs_pkg::SM_W_DEF,
  parameter int unsigned BM_W = acs_pkg::BM_W_DEF
) (
  input  logic [SM_W-1:0] metric,
  input  logic [BM_W-1:0] branch,
  output logic [SM_W-1:0] sum,
  output logic            clamped
);
  localparam int unsigned EXT_W = SM_W + 1;
  localparam int unsigned PAD_W = EXT_W - BM_W;

  // Widened add: the top bit is the final carry
  function automatic logic [EXT_W-1:0] wide_add(input logic [SM_W-1:0] a,
                                                input logic [BM_W-1:0] b);
    return {1'b0, a} + {{PAD_W{1'b0}}, b};
  endfunction

  logic [EXT_W-1:0] raw;

  assign raw     = wide_add(metric, branch);
  assign clamped = raw[SM_W];
  assign sum     = clamped ? {SM_W{1'b1}} : raw[SM_W-1:0];
endmodule

// File: rtl/acs_carry_cmp.sv
module acs_carry_cmp #(
  parameter int unsigned W = acs_pkg::SM_W_DEF
) (
  input  logic [W-1:0] upper,
  input  logic [W-1:0] lower,
  output logic         upper_gt
);
  // Carry-only chain of upper + ~lower with carry-in 0:
  // the final carry is set exactly when upper > lower.
  logic [W:0]   carry;
  logic [W-1:0] lower_n;

  assign lower_n  = ~lower;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_chain
    assign carry[g+1] = (upper[g] & lower_n[g]) |
                        ((upper[g] ^ lower_n[g]) & carry[g]);
  end

  assign upper_gt = carry[W];
endmodule

// File: rtl/acs_pick.sv
module acs_pick #(
  parameter int unsigned W = acs_pkg::SM_W_DEF
) (
  input  logic [W-1:0]   upper,
  input  logic [W-1:0]   lower,
  input  acs_pkg::pick_e sel,
  output logic [W-1:0]   chosen
);
  always_comb begin
    unique case (sel)
      acs_pkg::PICK_LOWER: chosen = lower;
      default:             chosen = upper;
    endcase
  end
endmodule

// File: rtl/acs_unit.sv
module acs_unit #(
  parameter int unsigned SM_W    = acs_pkg::SM_W_DEF,
  parameter int unsigned BM_W    = acs_pkg::BM_W_DEF,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SM_W-1:0] sm_up,
  input  logic [SM_W-1:0] sm_lo,
  input  logic [BM_W-1:0] bm_up,
  input  logic [BM_W-1:0] bm_lo,
  output logic [SM_W-1:0] nsm,
  output logic            path_sel
);
  // Named internal events, observed by the bound checker
  logic [SM_W-1:0] su_sum;
  logic [SM_W-1:0] sl_sum;
  logic            su_clamp;
  logic            sl_clamp;
  logic            upper_gt;
  acs_pkg::pick_e  pick;
  logic [SM_W-1:0] nsm_comb;

  acs_sat_add #(.SM_W(SM_W), .BM_W(BM_W)) u_add_up (
    .metric(sm_up), .branch(bm_up), .sum(su_sum), .clamped(su_clamp)
  );

  acs_sat_add #(.SM_W(SM_W), .BM_W(BM_W)) u_add_lo (
    .metric(sm_lo), .branch(bm_lo), .sum(sl_sum), .clamped(sl_clamp)
  );

  acs_carry_cmp #(.W(SM_W)) u_cmp (
    .upper(su_sum), .lower(sl_sum), .upper_gt(upper_gt)
  );

  assign pick = upper_gt ? acs_pkg::PICK_LOWER : acs_pkg::PICK_UPPER;

  acs_pick #(.W(SM_W)) u_pick (
    .upper(su_sum), .lower(sl_sum), .sel(pick), .chosen(nsm_comb)
  );

  if (REG_OUT) begin : g_reg
    logic [SM_W-1:0] nsm_q;
    logic            sel_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nsm_q <= '0;
        sel_q <= 1'b0;
      end else begin
        nsm_q <= nsm_comb;
        sel_q <= pick;
      end
    end
    assign nsm      = nsm_q;
    assign path_sel = sel_q;
  end else begin : g_comb
    assign nsm      = nsm_comb;
    assign path_sel = pick;
  end
endmodule

// File: rtl/acs_unit_chk.sv
module acs_unit_chk #(
  parameter int unsigned SM_W    = 8,
  parameter int unsigned BM_W    = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SM_W-1:0] sm_up,
  input logic [SM_W-1:0] sm_lo,
  input logic [BM_W-1:0] bm_up,
  input logic [BM_W-1:0] bm_lo,
  input logic [SM_W-1:0] su_sum,
  input logic [SM_W-1:0] sl_sum,
  input logic            su_clamp,
  input logic            sl_clamp,
  input logic            pick,
  input logic [SM_W-1:0] nsm_comb,
  input logic [SM_W-1:0] nsm,
  input logic            path_sel
);
  // R1: the upper sum never drops below its metric; a clamp gives all ones
  p_floor_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (su_sum >= sm_up) && (su_sum >= SM_W'(bm_up)));
  p_clamp_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    su_clamp |-> (su_sum == {SM_W{1'b1}}));

  // R2: same for the lower sum
  p_floor_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_sum >= sm_lo) && (sl_sum >= SM_W'(bm_lo)));
  p_clamp_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sl_clamp |-> (sl_sum == {SM_W{1'b1}}));

  // R3: the decision orders the candidates
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pick == (su_sum > sl_sum));

  // R4: a tie keeps the upper path
  p_tie_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (su_sum == sl_sum) |-> !pick);

  // R5: the survivor is one of the candidates and no larger than either
  p_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nsm_comb <= su_sum) && (nsm_comb <= sl_sum) &&
    ((nsm_comb == su_sum) || (nsm_comb == sl_sum)));

  // R6: the registered outputs follow the combinational result one edge later
  if (REG_OUT) begin : g_lat
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (nsm == $past(nsm_comb)) && (path_sel == $past(pick)));
  end
endmodule

bind acs_unit acs_unit_chk #(.SM_W(SM_W), .BM_W(BM_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sm_up(sm_up), .sm_lo(sm_lo), .bm_up(bm_up),
  .bm_lo(bm_lo), .su_sum(su_sum), .sl_sum(sl_sum), .su_clamp(su_clamp),
  .sl_clamp(sl_clamp), .pick(pick), .nsm_comb(nsm_comb), .nsm(nsm),
  .path_sel(path_sel)
);

// File: tb/tb_acs_unit.sv
`timescale 1ns/1ps
module tb_acs_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sm_up = '0, sm_lo = '0;
  logic [4:0] bm_up = '0, bm_lo = '0;
  logic [7:0] nsm;
  logic       path_sel;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp_nsm;
    logic       exp_sel;
    bit         tie;
    bit         clamp;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  acs_unit dut (
    .clk(clk), .rst_n(rst_n), .sm_up(sm_up), .sm_lo(sm_lo),
    .bm_up(bm_up), .bm_lo(bm_lo), .nsm(nsm), .path_sel(path_sel)
  );

  // Reference: compute in integers, then clamp at 255 (R1, R2)
  function automatic int ref_cand(int m, int b);
    int s = m + b;
    return (s > 255) ? 255 : s;
  endfunction

  task automatic drive(input int a, input int ba, input int c, input int bc);
    exp_t e;
    int u, l;
    @(negedge clk);
    sm_up = 8'(a); bm_up = 5'(ba); sm_lo = 8'(c); bm_lo = 5'(bc);
    u = ref_cand(a, ba);
    l = ref_cand(c, bc);
    e.tie     = (u == l);
    e.clamp   = (a + ba > 255) || (c + bc > 255);
    e.exp_sel = (u > l);                 // R3, R4
    e.exp_nsm = 8'((u > l) ? l : u);     // R5
    sb.push_back(e);
  endtask

  // Monitor: outputs are valid one edge after the driving negedge (R6)
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (path_sel !== e.exp_sel) begin
          bad++;
          $display("FAIL %s R6 path_sel actual=%0b expected=%0b",
                   e.tie ? "R4" : "R3", path_sel, e.exp_sel);
        end
        checks++;
        if (nsm !== e.exp_nsm) begin
          bad++;
          $display("FAIL %s R5 R6 nsm actual=%0d expected=%0d",
                   e.clamp ? "R1 R2" : "", nsm, e.exp_nsm);
        end
      end
    end
  end

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    #(3_000_000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    // R7: reset holds outputs at zero while inputs are busy
    sm_up = 8'd3; bm_up = 5'd1; sm_lo = 8'd200; bm_lo = 5'd9;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (nsm !== 8'd0 || path_sel !== 1'b0) begin
      bad++;
      $display("FAIL R7 reset actual=%0d/%0b expected=0/0", nsm, path_sel);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corners
    drive(0, 0, 0, 0);          // R4 tie at zero
    drive(255, 31, 255, 31);    // R1 R2 both clamped, R4 tie
    drive(250, 5, 240, 31);     // R1 exactly 255 vs R2 clamped: tie
    drive(240, 31, 100, 0);     // R1 clamps upper, lower survives
    drive(10, 0, 240, 20);      // R2 clamps lower, upper survives
    drive(100, 1, 100, 0);      // R3 upper bigger by one
    drive(100, 0, 100, 1);      // R3 lower bigger by one
    drive(128, 0, 127, 1);      // R4 tie across bit 7
    drive(0, 31, 31, 0);        // R4 tie mixed operands
    drive(254, 0, 255, 0);      // R3 near top
    // Random sweep
    for (int i = 0; i < 4000; i++)
      drive($urandom_range(0, 255), $urandom_range(0, 31),
            $urandom_range(0, 255), $urandom_range(0, 31));
    repeat (4) @(posedge clk);
    #6;
    done = 1'b1;
    finish_run();
  end
endmodule